// File: doc/BRIEF.md
# Double-Data-Rate Two-Word Burst SRAM Port

This block is the device side of a pipelined synchronous SRAM that carries two data words for every address it accepts. Each rising clock edge samples an active-low load strobe, a read/write select and a word address. Both clock edges are modelled as two halves of one cycle. The data buses are therefore two words wide in time: a rise-half word and a fall-half word.

A write takes its two data beats in the cycle after the address, with an active-low select per byte lane on each beat. The beats wait in a pending-write register and reach the array one edge later. A read presents its two words in the cycle after the next edge, which is the one-and-a-half-cycle read latency on a real pin. A read that lands on the pending write is served from that register, so commands may follow each other on every cycle with no gaps. The burst wraps inside an aligned pair of words. When the data path is idle the outputs are quiet, and an echo strobe pair runs freely for as long as the block is out of reset.

Top module: `ddrb_burst_port`

## Requirements
- R1: On a rising edge with `ld_n` = 0, `rw` = 1 starts a read and `rw` = 0 starts a write of the word pair that holds `addr`.
- R2: An edge with `ld_n` = 1 starts nothing. Data and lane selects presented in a cycle that follows no write leave the array unchanged, and no read data appears.
- R3: The two write beats (`d_rise` with `bws_rise_n`, `d_fall` with `bws_fall_n`) are sampled on the edge one cycle after the write command edge.
- R4: A read sampled on edge E drives `q_oe` = 1 and both words in the cycle that starts at edge E+1, and in no other cycle.
- R5: Bit l of a lane-select vector is active low and covers data bits [l*LANE_W +: LANE_W]. A lane held high on a beat leaves that byte of its word unchanged.
- R6: Burst order follows `addr[0]`. With 0, the rise beat is the even word of the pair and the fall beat is the odd word. With 1, the rise beat is the odd word and the fall beat is the even word. This holds for both reads and writes.
- R7: While `q_oe` = 0, `q_rise` and `q_fall` are all zeros, standing in for high impedance.
- R8: Out of reset, `cq` = 2'b01 and `cq_n` = 2'b10 in every cycle (bit 0 is the rise half). Every edge with `rst_n` = 0 sets both to 2'b00.
- R9: Commands are accepted on consecutive edges. A read issued directly after a write returns the newly written bytes merged with the unmasked old bytes.
- R10: An edge with `rst_n` = 0 clears `q_oe`, zeros the outputs and discards a write whose data was captured but not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address; bit 0 picks the first word of the burst |
| d_rise | input | LANE_W*LANES | First write beat |
| d_fall | input | LANE_W*LANES | Second write beat |
| bws_rise_n | input | LANES | Active-low lane selects for the first beat |
| bws_fall_n | input | LANES | Active-low lane selects for the second beat |
| q_rise | output | LANE_W*LANES | First read word |
| q_fall | output | LANE_W*LANES | Second read word |
| q_oe | output | 1 | Read data valid and driven |
| cq | output | 2 | Echo strobe levels {fall half, rise half} |
| cq_n | output | 2 | Complementary echo strobe levels |

## Verification
The bench targets a read issued on the edge directly after a write to the same pair, with some lanes masked. A design without the forwarding merge would return the old array contents, and one that forwards whole words would wipe the masked bytes. Odd-start bursts are mixed with even-start ones, so a design that swapped beats only on one path shows up as crossed words. Reset is asserted while a captured write is still pending, and a later read of that pair must show the older value; a design that commits during reset would show the discarded data. Idle cycles carry junk data with active lane selects, which catches a design that writes without a command.

// File: rtl/ddrb_pkg.sv
// Shared definitions for the two-word burst SRAM port.
// Assumes: one command per clock, a burst always spans one aligned word pair.
package ddrb_pkg;

    // Command held in the first pipeline stage
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } ddrb_op_e;

    // Which word of the pair a beat addresses: the start word, then its partner
    function automatic logic beat_hits_odd(input logic start_odd, input logic second_beat);
        return start_odd ^ second_beat;
    endfunction

endpackage

// File: rtl/ddrb_cmd_stage.sv
// Command stage: registers the decoded command and address on each edge.
// Assumes: ld_n is active low; rw high selects a read.
module ddrb_cmd_stage
    import ddrb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output ddrb_op_e          op_a,
    output logic [ADDR_W-1:0] addr_a
);

    // Decode and hold the command sampled on this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a   <= OP_IDLE;
            addr_a <= '0;
        end else begin
            if (ld_n)    op_a <= OP_IDLE;
            else if (rw) op_a <= OP_READ;
            else         op_a <= OP_WRITE;
            if (!ld_n) addr_a <= addr;
        end
    end

    // R2
    nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (op_a == OP_IDLE));

endmodule

// File: rtl/ddrb_wr_stage.sv
// Write capture: takes both data beats one cycle after a write command and
// maps them onto the even and odd words of the pair. Holds them as the
// pending write until the store commits them on the following edge.
// Assumes: lane selects are active low and belong to the beat they travel with.
module ddrb_wr_stage
    import ddrb_pkg::*;
#(
    parameter  int ADDR_W = 5,
    parameter  int LANE_W = 9,
    parameter  int LANES  = 2,
    localparam int DW     = LANE_W * LANES,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ddrb_op_e          op_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DW-1:0]     d_rise,
    input  logic [DW-1:0]     d_fall,
    input  logic [LANES-1:0]  bws_rise_n,
    input  logic [LANES-1:0]  bws_fall_n,
    output logic              pend_vld,
    output logic [PAIR_W-1:0] pend_pair,
    output logic [DW-1:0]     pend_even_d,
    output logic [DW-1:0]     pend_odd_d,
    output logic [LANES-1:0]  pend_even_en,
    output logic [LANES-1:0]  pend_odd_en
);

    logic first_is_odd;
    assign first_is_odd = beat_hits_odd(addr_a[0], 1'b0);

    // Capture beats into the pending-write register in burst order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld     <= 1'b0;
            pend_pair    <= '0;
            pend_even_d  <= '0;
            pend_odd_d   <= '0;
            pend_even_en <= '0;
            pend_odd_en  <= '0;
        end else begin
            pend_vld <= (op_a == OP_WRITE);
            if (op_a == OP_WRITE) begin
                pend_pair <= addr_a[ADDR_W-1:1];
                if (first_is_odd) begin
                    pend_odd_d   <= d_rise;
                    pend_odd_en  <= ~bws_rise_n;
                    pend_even_d  <= d_fall;
                    pend_even_en <= ~bws_fall_n;
                end else begin
                    pend_even_d  <= d_rise;
                    pend_even_en <= ~bws_rise_n;
                    pend_odd_d   <= d_fall;
                    pend_odd_en  <= ~bws_fall_n;
                end
            end
        end
    end

    // R3
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == OP_WRITE) |=> pend_vld);

    // R2
    no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a != OP_WRITE) |=> !pend_vld);

endmodule

// File: rtl/ddrb_store.sv
// Word-pair storage with byte-lane commit and a forwarding read port.
// The pending write is committed on the edge after capture unless reset is
// low on that edge. Reads of the pair held in the pending register take the
// enabled lanes from it and the rest from the array.
// Assumes: the array has no reset; contents are defined once written.
module ddrb_store #(
    parameter  int ADDR_W = 5,
    parameter  int LANE_W = 9,
    parameter  int LANES  = 2,
    localparam int DW     = LANE_W * LANES,
    localparam int PAIR_W = ADDR_W - 1,
    localparam int PAIRS  = 1 << PAIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_vld,
    input  logic [PAIR_W-1:0] pend_pair,
    input  logic [DW-1:0]     pend_even_d,
    input  logic [DW-1:0]     pend_odd_d,
    input  logic [LANES-1:0]  pend_even_en,
    input  logic [LANES-1:0]  pend_odd_en,
    input  logic [PAIR_W-1:0] rd_pair,
    output logic [DW-1:0]     even_q,
    output logic [DW-1:0]     odd_q
);

    logic [DW-1:0] mem_even [PAIRS];
    logic [DW-1:0] mem_odd  [PAIRS];
    logic          fwd_hit;

    // Commit enabled lanes of the pending write; reset drops it
    always_ff @(posedge clk) begin
        if (rst_n && pend_vld) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_even_en[l])
                    mem_even[pend_pair][l*LANE_W +: LANE_W] <= pend_even_d[l*LANE_W +: LANE_W];
                if (pend_odd_en[l])
                    mem_odd[pend_pair][l*LANE_W +: LANE_W] <= pend_odd_d[l*LANE_W +: LANE_W];
            end
        end
    end

    assign fwd_hit = pend_vld && (pend_pair == rd_pair);

    // Per-lane merge of the pending write over the stored pair
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign even_q[l*LANE_W +: LANE_W] = (fwd_hit && pend_even_en[l])
            ? pend_even_d[l*LANE_W +: LANE_W] : mem_even[rd_pair][l*LANE_W +: LANE_W];
        assign odd_q[l*LANE_W +: LANE_W] = (fwd_hit && pend_odd_en[l])
            ? pend_odd_d[l*LANE_W +: LANE_W] : mem_odd[rd_pair][l*LANE_W +: LANE_W];
    end

    // R9
    fwd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_hit && pend_even_en[0]) |-> (even_q[LANE_W-1:0] == pend_even_d[LANE_W-1:0]));

endmodule

// File: rtl/ddrb_rd_out.sv
// Read output register: loads both words in burst order on the edge after
// a read command and holds zeros with the enable low otherwise.
// Assumes: the store port already reflects the pair of the staged command.
module ddrb_rd_out
    import ddrb_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ddrb_op_e      op_a,
    input  logic          start_odd,
    input  logic [DW-1:0] even_q,
    input  logic [DW-1:0] odd_q,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall,
    output logic          q_oe
);

    // Drive the burst for one cycle, or rest at zero
    always_ff @(posedge clk) begin
        if (!rst_n || op_a != OP_READ) begin
            q_oe   <= 1'b0;
            q_rise <= '0;
            q_fall <= '0;
        end else begin
            q_oe   <= 1'b1;
            q_rise <= beat_hits_odd(start_odd, 1'b0) ? odd_q : even_q;
            q_fall <= beat_hits_odd(start_odd, 1'b1) ? odd_q : even_q;
        end
    end

    // R7
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q_rise == '0 && q_fall == '0));

endmodule

// File: rtl/ddrb_echo.sv
// Echo strobe generator: a free-running complementary pair expressed as
// the level in each half cycle, held low while reset is applied.
// Assumes: output data changes at the start of the rise half.
module ddrb_echo (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] cq,
    output logic [1:0] cq_n
);

    logic run;

    // Start the strobes on the first edge out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= 1'b1;
    end

    assign cq   = {1'b0, run};
    assign cq_n = {run, 1'b0};

    // R8
    echo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cq != 2'b00) |-> (cq_n == ~cq));

    // R8
    echo_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cq == 2'b01));

endmodule

// File: rtl/ddrb_burst_port.sv
// Two-word burst SRAM port: command stage, write capture, pair store with
// forwarding, read output register and echo strobes.
// Assumes: both clock edges are folded into rise and fall halves of one cycle.
module ddrb_burst_port
    import ddrb_pkg::*;
#(
    parameter  int ADDR_W = 5,
    parameter  int LANE_W = 9,
    parameter  int LANES  = 2,
    localparam int DW     = LANE_W * LANES,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     d_rise,
    input  logic [DW-1:0]     d_fall,
    input  logic [LANES-1:0]  bws_rise_n,
    input  logic [LANES-1:0]  bws_fall_n,
    output logic [DW-1:0]     q_rise,
    output logic [DW-1:0]     q_fall,
    output logic              q_oe,
    output logic [1:0]        cq,
    output logic [1:0]        cq_n
);

    ddrb_op_e          op_a;
    logic [ADDR_W-1:0] addr_a;
    logic              pend_vld;
    logic [PAIR_W-1:0] pend_pair;
    logic [DW-1:0]     pend_even_d, pend_odd_d;
    logic [LANES-1:0]  pend_even_en, pend_odd_en;
    logic [DW-1:0]     even_q, odd_q;

    ddrb_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .op_a(op_a), .addr_a(addr_a)
    );

    ddrb_wr_stage #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .addr_a(addr_a),
        .d_rise(d_rise), .d_fall(d_fall),
        .bws_rise_n(bws_rise_n), .bws_fall_n(bws_fall_n),
        .pend_vld(pend_vld), .pend_pair(pend_pair),
        .pend_even_d(pend_even_d), .pend_odd_d(pend_odd_d),
        .pend_even_en(pend_even_en), .pend_odd_en(pend_odd_en)
    );

    ddrb_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_pair(pend_pair),
        .pend_even_d(pend_even_d), .pend_odd_d(pend_odd_d),
        .pend_even_en(pend_even_en), .pend_odd_en(pend_odd_en),
        .rd_pair(addr_a[ADDR_W-1:1]), .even_q(even_q), .odd_q(odd_q)
    );

    ddrb_rd_out #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .start_odd(addr_a[0]),
        .even_q(even_q), .odd_q(odd_q),
        .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe)
    );

    ddrb_echo u_echo (
        .clk(clk), .rst_n(rst_n), .cq(cq), .cq_n(cq_n)
    );

    // R4
    read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && rw) |=> ##1 q_oe);

    // R2
    nop_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> ##1 !q_oe);

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_oe && cq == 2'b00 && q_rise == '0 && q_fall == '0));

endmodule

// File: tb/sim_ddrb_burst_port.sv
// Scoreboard bench: the driver keeps a word model and queues expected bursts;
// the monitor compares them in the cycle they are due.
module sim_ddrb_burst_port;
    localparam int AW = 5, LW = 9, LN = 2, DW = LW * LN, WORDS = 1 << AW;

    logic          clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] d_rise = '0, d_fall = '0;
    logic [LN-1:0] bws_rise_n = '1, bws_fall_n = '1;
    logic [DW-1:0] q_rise, q_fall;
    logic          q_oe;
    logic [1:0]    cq, cq_n;

    ddrb_burst_port #(.ADDR_W(AW), .LANE_W(LW), .LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .d_rise(d_rise), .d_fall(d_fall), .bws_rise_n(bws_rise_n), .bws_fall_n(bws_fall_n),
        .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe), .cq(cq), .cq_n(cq_n)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [WORDS];
    int            due_q[$];
    logic [DW-1:0] er_q[$], ef_q[$];
    string         tag_q[$];

    bit            st_vld = 1'b0, skip_model = 1'b0;
    int            st_a = 0;
    logic [DW-1:0] st_dr, st_df;
    logic [LN-1:0] st_mr, st_mf;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one beat to the model with active-low lane selects
    task automatic put_word(input int a, input logic [DW-1:0] d, input logic [LN-1:0] m);
        for (int l = 0; l < LN; l++)
            if (!m[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
    endtask

    // One cycle: command now, data beats of the previous write (or junk)
    task automatic step(input bit cmd, input bit rd, input int a, input logic [DW-1:0] dr,
                        input logic [DW-1:0] df, input logic [LN-1:0] mr,
                        input logic [LN-1:0] mf, input string tag);
        @(negedge clk);
        if (st_vld) begin
            d_rise = st_dr; d_fall = st_df; bws_rise_n = st_mr; bws_fall_n = st_mf;
            if (!skip_model) begin
                put_word(st_a, st_dr, st_mr);
                put_word(st_a ^ 1, st_df, st_mf);
            end
        end else begin
            d_rise = DW'($urandom); d_fall = DW'($urandom);
            bws_rise_n = '0; bws_fall_n = '0;
        end
        ld_n = !cmd; rw = rd; addr = AW'(a);
        if (cmd && rd) begin
            due_q.push_back(cyc + 2);
            er_q.push_back(model[a]);
            ef_q.push_back(model[a ^ 1]);
            tag_q.push_back(tag);
        end
        st_vld = cmd && !rd;
        st_a = a; st_dr = dr; st_df = df; st_mr = mr; st_mf = mf;
    endtask

    task automatic nop();
        step(1'b0, 1'b0, 0, '0, '0, '1, '1, "R2");
    endtask

    // Monitor: compare due bursts, otherwise expect quiet outputs
    initial begin
        forever begin
            logic r;
            @(posedge clk);
            r = rst_n;
            #2;
            check("R8", "cq", 32'(cq), r ? 32'h1 : 32'h0);
            check("R8", "cq_n", 32'(cq_n), r ? 32'h2 : 32'h0);
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check("R4", "q_oe", 32'(q_oe), 32'h1);
                check(tag_q[0], "q_rise", 32'(q_rise), 32'(er_q[0]));
                check(tag_q[0], "q_fall", 32'(q_fall), 32'(ef_q[0]));
                void'(due_q.pop_front()); void'(er_q.pop_front());
                void'(ef_q.pop_front()); void'(tag_q.pop_front());
            end else begin
                check("R7", "idle q_oe", 32'(q_oe), 32'h0);
                check("R7", "idle q_rise", 32'(q_rise), 32'h0);
                check("R7", "idle q_fall", 32'(q_fall), 32'h0);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "reset q_oe", 32'(q_oe), 32'h0);
        check("R10", "reset cq", 32'(cq), 32'h0);
        rst_n = 1'b1;
        nop(); nop();

        // R1 R3 fill every pair with even-start writes, then read back
        for (int p = 0; p < WORDS / 2; p++)
            step(1, 0, 2 * p, DW'(p * 4099 + 7), DW'(p * 977 + 300), '0, '0, "R1");
        nop();
        for (int p = 0; p < WORDS / 2; p++)
            step(1, 1, 2 * p, '0, '0, '1, '1, "R1");
        nop(); nop();

        // R6 odd-start writes and reads in both orders
        for (int p = 0; p < 4; p++)
            step(1, 0, 2 * p + 1, DW'(p * 31 + 18'h2A000), DW'(p * 53 + 18'h15000), '0, '0, "R6");
        nop();
        for (int p = 0; p < 4; p++) begin
            step(1, 1, 2 * p + 1, '0, '0, '1, '1, "R6");
            step(1, 1, 2 * p, '0, '0, '1, '1, "R6");
        end
        nop(); nop();

        // R5 lane masks on each beat
        step(1, 0, 10, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b10, "R5");
        nop(); nop();
        step(1, 1, 10, '0, '0, '1, '1, "R5");
        step(1, 0, 13, 18'h12345, 18'h2ABCD, 2'b10, 2'b11, "R5");
        nop(); nop();
        step(1, 1, 12, '0, '0, '1, '1, "R5");
        nop(); nop();

        // R2 idle cycles carry junk with active selects; nothing may change
        repeat (6) nop();
        for (int a = 0; a < WORDS; a += 2) step(1, 1, a, '0, '0, '1, '1, "R2");
        nop(); nop();

        // R9 back-to-back: write then read of the same pair, masked
        step(1, 0, 6, 18'h1F0F0, 18'h0A5A5, 2'b10, 2'b00, "R9");
        step(1, 1, 6, '0, '0, '1, '1, "R9");
        step(1, 0, 20, 18'h33333, 18'h0CCCC, 2'b00, 2'b01, "R9");
        step(1, 1, 21, '0, '0, '1, '1, "R9");
        step(1, 0, 8, 18'h11111, 18'h22222, 2'b00, 2'b00, "R9");
        step(1, 0, 8, 18'h0BEEF, 18'h0F00D, 2'b01, 2'b00, "R9");
        step(1, 1, 9, '0, '0, '1, '1, "R9");
        step(1, 1, 8, '0, '0, '1, '1, "R9");
        nop(); nop();

        // R9 random mix of back-to-back traffic
        for (int i = 0; i < 600; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k < 5)
                step(1, 0, int'($urandom % WORDS), DW'($urandom), DW'($urandom),
                     LN'($urandom), LN'($urandom), "R9");
            else if (k < 9)
                step(1, 1, int'($urandom % WORDS), '0, '0, '1, '1, "R9");
            else
                nop();
        end
        repeat (3) nop();

        // R10 reset drops a captured write before its commit edge
        step(1, 0, 4, 18'h3C3C3, 18'h3C3C3, '0, '0, "R10");
        skip_model = 1'b1;
        nop();
        skip_model = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; ld_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 1, 4, '0, '0, '1, '1, "R10");
        step(1, 1, 5, '0, '0, '1, '1, "R10");
        repeat (4) nop();

        check("R4", "bursts left undelivered", 32'(due_q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule